// File: doc/BRIEF.md
# Framed Packet Bit Serializer for a Radio Transceiver

This block turns one 32-bit measurement word into a complete radio frame and shifts it out, one bit at a time, to a transceiver that supplies its own bit clock. The frame opens with a run of alternating-bit bytes that lets the receiver settle. A fixed three-byte sync word comes next, which the receiver matches before it accepts any data. The four payload bytes follow, and the frame closes with a 16-bit CRC computed over those payload bytes.

The transceiver's bit clock is asynchronous to the local clock. It passes through a two-flop synchronizer, and its rising edges are detected in the local domain. Each detected rising edge moves the serial output to the next frame bit. A select output stays high for the whole packet. One rising edge after the final CRC bit, select drops and a one-cycle done pulse is raised. The block then waits in idle for the next start strobe.

Top module: `radio_frame_tx`

## Requirements
- R1: While reset is high, and in the first cycle after it, `sel_o`, `sdata_o` and `done_o` are all 0.
- R2: A `start_i` pulse in idle latches `payload_i` and raises `sel_o` on the next clock edge. `sdata_o` stays 0 until the first rising edge of `dclk_i` is detected.
- R3: The first 64 bits sent are eight bytes of value 0xAA. All bytes go out most significant bit first, so the line starts 1,0,1,0.
- R4: Bits 64 to 87 are the sync word (default 0xD391DA), most significant bit first.
- R5: Bits 88 to 119 are the latched payload, starting at `payload_i[31]` and ending at `payload_i[0]`.
- R6: Bits 120 to 135 are a CRC-16 of the payload, most significant bit first. The CRC uses polynomial 0x1021 and initial value 0xFFFF, with no bit reflection and no final XOR. It processes the payload bits in the order they are sent.
- R7: `sdata_o` changes only in response to a detected rising edge of `dclk_i`. It holds its value across falling edges and between edges.
- R8: The rising edge after the 136th bit clears `sel_o` and `sdata_o`. In that same cycle `done_o` is 1, and it is 1 for exactly one cycle.
- R9: A `start_i` pulse during a packet has no effect. The frame in progress continues unchanged, with the original payload, and produces only one done pulse.
- R10: In idle, edges on `dclk_i` leave `sel_o`, `sdata_o` and `done_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle strobe that begins a packet |
| payload_i | input | 32 | Measurement word, sampled on the start strobe |
| dclk_i | input | 1 | Bit clock from the transceiver, asynchronous |
| sdata_o | output | 1 | Serial frame data to the transceiver |
| sel_o | output | 1 | Transceiver select, high for the whole packet |
| done_o | output | 1 | One-cycle pulse when the packet has finished |

## Verification
Errors in the bit counter or the shift register appear on `sdata_o` at a single bit position. The bench compares every one of the 136 bits of every packet, so the failure is reported at the first wrong data-clock edge. An error in the CRC or in payload latching affects only the last 48 bits and is caught within that frame. A wrong end-of-frame count shows up one data-clock edge late or early, as `sel_o` and `done_o` in the wrong place. A reload on an ignored start shows up as a restarted preamble within one edge.

// File: rtl/radio_frame_pkg.sv
package radio_frame_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned PAY_BYTES  = 4;
    localparam int unsigned CRC_BYTES  = 2;
    localparam int unsigned PAY_W      = PAY_BYTES * BYTE_W;
    localparam int unsigned CRC_W      = CRC_BYTES * BYTE_W;

    localparam logic [CRC_W-1:0]  CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0]  CRC_SEED = 16'hFFFF;
    localparam logic [BYTE_W-1:0] PRE_BYTE = 8'hAA;

    typedef enum logic [0:0] {
        SER_IDLE = 1'b0,
        SER_SEND = 1'b1
    } ser_state_e;

    // CRC over the payload, taking bits in the order they go out (MSB first)
    function automatic logic [CRC_W-1:0] crc_of_payload(input logic [PAY_W-1:0] word);
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = CRC_SEED;
        for (int k = PAY_W - 1; k >= 0; k--) begin
            fb  = acc[CRC_W-1] ^ word[k];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) acc = acc ^ CRC_POLY;
        end
        return acc;
    endfunction

endpackage

// File: rtl/dclk_edge_sync.sv
module dclk_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic dclk_i,
    output logic rise_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= dclk_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);  // R7

endmodule

// File: rtl/frame_assembler.sv
module frame_assembler
    import radio_frame_pkg::*;
#(
    parameter int unsigned PRE_BYTES  = 8,
    parameter int unsigned SYNC_BYTES = 3,
    parameter logic [SYNC_BYTES*BYTE_W-1:0] SYNC_WORD = 24'hD391DA,
    localparam int unsigned PRE_W   = PRE_BYTES * BYTE_W,
    localparam int unsigned SYNC_W  = SYNC_BYTES * BYTE_W,
    localparam int unsigned FRAME_W = PRE_W + SYNC_W + PAY_W + CRC_W
) (
    input  logic [PAY_W-1:0]   payload_i,
    output logic [FRAME_W-1:0] frame_o
);
    logic [PRE_W-1:0] pre_bits;
    logic [CRC_W-1:0] crc_bits;

    for (genvar b = 0; b < PRE_BYTES; b++) begin : g_pre
        assign pre_bits[b*BYTE_W +: BYTE_W] = PRE_BYTE;
    end

    assign crc_bits = crc_of_payload(payload_i);
    assign frame_o  = {pre_bits, SYNC_WORD, payload_i, crc_bits};

endmodule

// File: rtl/bit_serializer.sv
module bit_serializer
    import radio_frame_pkg::*;
#(
    parameter int unsigned FRAME_W = 136,
    localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               tick_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               sdata_o,
    output logic               sel_o,
    output logic               done_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_W);

    ser_state_e         state_q;
    logic [FRAME_W-1:0] shift_q;
    logic [CNT_W-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SER_IDLE;
            shift_q <= '0;
            cnt_q   <= '0;
            sdata_o <= 1'b0;
            sel_o   <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                SER_IDLE: begin
                    if (start_i) begin
                        shift_q <= frame_i;
                        cnt_q   <= '0;
                        sdata_o <= 1'b0;
                        sel_o   <= 1'b1;
                        state_q <= SER_SEND;
                    end
                end
                SER_SEND: begin
                    if (tick_i) begin
                        if (cnt_q == LAST_CNT) begin
                            sdata_o <= 1'b0;
                            sel_o   <= 1'b0;
                            done_o  <= 1'b1;
                            state_q <= SER_IDLE;
                        end else begin
                            sdata_o <= shift_q[FRAME_W-1];
                            shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
                            cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SER_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);  // R8
    AST_SEL_FALLS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_o) |-> done_o);  // R8
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_CNT);  // R8
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        (state_q == SER_SEND && $past(state_q == SER_SEND) && !$past(tick_i))
        |-> $stable(sdata_o));  // R7
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == SER_SEND && start_i && !tick_i) |=> $stable(shift_q));  // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == SER_IDLE) |-> (!sel_o && !sdata_o));  // R10

endmodule

// File: rtl/radio_frame_tx.sv
module radio_frame_tx
    import radio_frame_pkg::*;
#(
    parameter int unsigned PRE_BYTES  = 8,
    parameter int unsigned SYNC_BYTES = 3,
    parameter logic [SYNC_BYTES*8-1:0] SYNC_WORD = 24'hD391DA
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [31:0] payload_i,
    input  logic        dclk_i,
    output logic        sdata_o,
    output logic        sel_o,
    output logic        done_o
);
    localparam int unsigned FRAME_W = (PRE_BYTES + SYNC_BYTES + PAY_BYTES + CRC_BYTES) * BYTE_W;

    logic               bit_tick;
    logic [FRAME_W-1:0] frame_w;

    dclk_edge_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .dclk_i (dclk_i),
        .rise_o (bit_tick)
    );

    frame_assembler #(
        .PRE_BYTES  (PRE_BYTES),
        .SYNC_BYTES (SYNC_BYTES),
        .SYNC_WORD  (SYNC_WORD)
    ) u_frame (
        .payload_i (payload_i),
        .frame_o   (frame_w)
    );

    bit_serializer #(
        .FRAME_W (FRAME_W)
    ) u_ser (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .tick_i  (bit_tick),
        .frame_i (frame_w),
        .sdata_o (sdata_o),
        .sel_o   (sel_o),
        .done_o  (done_o)
    );

    AST_START_RAISES_SEL: assert property (@(posedge clk) disable iff (rst)
        (start_i && !sel_o && !done_o) |=> sel_o);  // R2
    AST_DONE_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!sel_o && !sdata_o));  // R8

endmodule

// File: tb/radio_frame_tx_tb.sv
module radio_frame_tx_tb;
    localparam int NBITS = 136;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] payload_i = '0;
    logic        dclk_i = 1'b0;
    logic        sdata_o;
    logic        sel_o;
    logic        done_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    radio_frame_tx u_dut (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .payload_i (payload_i),
        .dclk_i    (dclk_i),
        .sdata_o   (sdata_o),
        .sel_o     (sel_o),
        .done_o    (done_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [31:0] w);
        logic [15:0] r = 16'hFFFF;
        for (int byt = 3; byt >= 0; byt--) begin
            logic [7:0] b = w[byt*8 +: 8];
            r = r ^ {b, 8'h00};
            for (int s = 0; s < 8; s++)
                r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        end
        return r;
    endfunction

    function automatic logic [NBITS-1:0] ref_frame(input logic [31:0] w);
        return {{8{8'hAA}}, 24'hD391DA, w, ref_crc(w)};
    endfunction

    function automatic string req_of(input int i);
        if (i < 64)  return "R3";
        if (i < 88)  return "R4";
        if (i < 120) return "R5";
        return "R6";
    endfunction

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dclk_high();
        dclk_i = 1'b1;
        wait_cycles(6);
    endtask

    task automatic dclk_low();
        dclk_i = 1'b0;
        wait_cycles(6);
    endtask

    task automatic run_packet(input logic [31:0] w, input bit inject);
        logic [NBITS-1:0] exp_f = ref_frame(w);
        int dones = 0;
        payload_i = w;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        payload_i = ~w;
        @(negedge clk);
        chk(sel_o == 1'b1, "R2", sel_o, 1);
        chk(sdata_o == 1'b0, "R2", sdata_o, 0);
        for (int i = 0; i < NBITS; i++) begin
            logic held;
            dclk_high();
            chk(sdata_o == exp_f[NBITS-1-i], req_of(i), sdata_o, exp_f[NBITS-1-i]);
            held = sdata_o;
            if (inject && i == 50) begin
                payload_i = 32'h5A5A_0F0F;
                start_i   = 1'b1;
                @(negedge clk);
                start_i   = 1'b0;
                chk(sel_o == 1'b1, "R9", sel_o, 1);
            end
            dclk_low();
            chk(sdata_o == held, "R7", sdata_o, held);
            chk(sel_o == 1'b1, "R8", sel_o, 1);
        end
        dclk_i = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (done_o) dones++;
        end
        chk(dones == 1, "R8", dones, 1);
        chk(sel_o == 1'b0, "R8", sel_o, 0);
        chk(sdata_o == 1'b0, "R8", sdata_o, 0);
        dclk_low();
        chk(done_o == 1'b0, "R8", done_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [10] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8000_0001,
                                   32'h4148_0000, 32'hC2F6_E979, 32'h0000_0001, 32'hDEAD_BEEF,
                                   32'h7F80_0000, 32'hA5A5_A5A5};
        wait_cycles(3);
        chk(sel_o == 1'b0 && sdata_o == 1'b0 && done_o == 1'b0, "R1", {sel_o, sdata_o, done_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sel_o == 1'b0 && sdata_o == 1'b0 && done_o == 1'b0, "R1", {sel_o, sdata_o, done_o}, 0);

        // R10: data clock activity while idle
        for (int k = 0; k < 4; k++) begin
            dclk_high();
            chk(sel_o == 1'b0 && sdata_o == 1'b0 && done_o == 1'b0, "R10",
                {sel_o, sdata_o, done_o}, 0);
            dclk_low();
        end

        for (int p = 0; p < 10; p++) begin
            run_packet(pats[p], (p == 3) || (p == 8));
            wait_cycles(4);
        end

        // R10 again after packets
        dclk_high();
        chk(sel_o == 1'b0 && sdata_o == 1'b0 && done_o == 1'b0, "R10", {sel_o, sdata_o, done_o}, 0);
        dclk_low();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule